// File: doc/BRIEF.md
# Round-Robin Serial Converter Scan Controller

This block is the host side of a four-wire serial link to an external 12-bit multi-channel sampling converter. It produces the chip select and a serial clock divided down from the system clock. It walks a programmable set of up to eight channels in a fixed rotation and returns each conversion as a channel number paired with a 12-bit code and a one-cycle strobe.

The converter always returns the sample that was requested one frame earlier. For this reason the controller keeps the address it sent during the previous frame and uses it to tag the word arriving now. The converter's channel is unknown after an idle period, so the first frame after every start acts only as a primer, and its result is thrown away.

Two framing styles are available. In continuous framing the chip select stays low and frames follow one another with no gap. In burst framing the chip select is raised for a fixed gap after every frame, which lets the converter power down. A status bit goes with each result and reports a returned word whose four leading bits were not all zero.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is held and right after it is released, spi_cs_n = 1, spi_sclk = 1, spi_mosi = 0 and res_valid = 0.
- R2: spi_sclk is high whenever spi_cs_n is high. Inside a frame every low phase and every high phase of spi_sclk lasts exactly HALF_CLKS system clocks, and every chip-select-low period holds a whole multiple of 16 rising edges.
- R3: spi_cs_n falls while spi_sclk is high, and spi_sclk stays high for HALF_CLKS system clocks (at least one) before the first falling edge of the frame.
- R4: spi_mosi changes only with falling spi_sclk edges. The byte seen on rising edges 1 to 8 (first edge = bit 7) carries the channel number in binary at bits 5 (MSB) to 3, and its other bits are 0. spi_mosi is 0 on rising edges 9 to 16 and whenever spi_cs_n is high.
- R5: spi_miso is sampled at each rising spi_sclk edge. Of the 16 bits of a frame, bits 1 to 4 are the leading bits and bits 5 to 16 form res_code, MSB first.
- R6: A result read in frame k is tagged on res_chan with the channel sent in frame k-1.
- R7: After each start from idle, the first frame produces no res_valid. The first delivered result is the one read in the second frame.
- R8: Enabled channels (chan_mask bit n enables channel n) are visited in ascending order, starting from the lowest enabled one, skipping disabled ones and wrapping from the highest enabled back to the lowest.
- R9: While run = 0 or chan_mask = 0, no new frame starts and spi_cs_n stays high. A frame already in progress completes.
- R10: With burst_mode = 0, spi_cs_n stays low across back-to-back frames, and the first falling edge of the next frame comes HALF_CLKS clocks after rising edge 16.
- R11: With burst_mode = 1, spi_cs_n goes high for exactly GAP_CLKS clocks between frames. Frames after a gap keep the address pipeline, so they are not primers.
- R12: res_err is 1 with a result exactly when any of its four leading bits was 1, and res_code is still delivered.
- R13: res_valid is a single-cycle pulse that appears together with the 16th rising spi_sclk edge of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Scanning runs while high |
| burst_mode | input | 1 | 1 = raise chip select between frames, 0 = continuous frames |
| chan_mask | input | NUM_CH | Channel enable, bit n enables channel n |
| spi_cs_n | output | 1 | Chip select to the converter, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Control bits to the converter |
| spi_miso | input | 1 | Result bits from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | CH_W | Channel the result belongs to |
| res_code | output | CODE_W | Conversion result |
| res_err | output | 1 | Leading bits of the word were not all zero |

## Verification
The bench connects a behavioural converter that latches the address bits and returns a word whose top code bits name the channel it converted and whose low bits count its conversions. A tagging slip or a primer that leaks through therefore shows up as a mismatch in either field. A full mask checks plain rotation. A sparse mask with channels 2, 5 and 7 checks skipping and wrap-around. A single-channel mask with injected leading ones separates the error flag from the code path. Continuous and burst runs differ in chip-select behaviour and gap length, and a zero mask checks that the controller stays idle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // chip select high, waiting for run and a channel
    ST_LEAD,   // chip select low, clock held high before first fall
    ST_LOW,    // serial clock low phase
    ST_HIGH,   // serial clock high phase
    ST_GAP     // burst framing: chip select high between frames
  } scan_state_t;
endpackage

// File: rtl/adc_scan_divider.sv
module adc_scan_divider #(
  parameter int HALF_CLKS = 4,
  localparam int HALF_W = $clog2(HALF_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = en && (cnt == HALF_W'(HALF_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_scan_chansel.sv
module adc_scan_chansel #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   last,
  output logic [CH_W-1:0]   next_ch,
  output logic              any_en
);
  // Nearest enabled channel after 'last', wrapping; smallest offset wins.
  function automatic logic [CH_W-1:0] pick_next(input logic [NUM_CH-1:0] m,
                                               input logic [CH_W-1:0] from);
    logic [CH_W-1:0] pick;
    int idx;
    pick = from;
    for (int off = NUM_CH; off >= 1; off--) begin
      idx = (int'(from) + off) % NUM_CH;
      if (m[CH_W'(idx)]) pick = CH_W'(idx);
    end
    return pick;
  endfunction

  assign next_ch = pick_next(mask, last);
  assign any_en  = |mask;
endmodule

// File: rtl/adc_scan_shifter.sv
module adc_scan_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              din,
  output logic [WORD_W-1:0] word_now
);
  logic [WORD_W-2:0] sh;

  // word_now includes the bit being sampled in this cycle
  assign word_now = {sh, din};

  always_ff @(posedge clk) begin
    if (!rst_n)     sh <= '0;
    else if (shift) sh <= word_now[WORD_W-2:0];
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int CODE_W    = 12,
  parameter int LEAD_W    = 4,
  parameter int CTRL_W    = 8,
  parameter int ADDR_LSB  = 3,
  parameter int HALF_CLKS = 4,
  parameter int GAP_CLKS  = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int WORD_W = LEAD_W + CODE_W,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int GAP_W  = $clog2(GAP_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              burst_mode,
  input  logic [NUM_CH-1:0] chan_mask,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chan,
  output logic [CODE_W-1:0] res_code,
  output logic              res_err
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  // Control bit to present after falling edge idx (0-based) for channel ch
  function automatic logic ctrl_bit(input logic [BIT_W-1:0] idx,
                                    input logic [CH_W-1:0] ch);
    int pos;
    pos = CTRL_W - 1 - int'(idx);
    if (pos >= ADDR_LSB && pos < ADDR_LSB + CH_W) return ch[CH_W'(pos - ADDR_LSB)];
    return 1'b0;
  endfunction

  scan_state_t       state;
  logic [BIT_W-1:0]  bit_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [CH_W-1:0]   cur_ch, prev_ch;
  logic              dummy_frame;

  // Named internal events
  logic              half_tick, frame_done, frame_end, keep_going, any_en;
  logic [CH_W-1:0]   next_ch, search_from;
  logic [WORD_W-1:0] word_now;

  assign frame_done  = (state == ST_LOW)  && half_tick && (bit_cnt == LAST_BIT);
  assign frame_end   = (state == ST_HIGH) && half_tick && (bit_cnt == LAST_BIT);
  assign keep_going  = run && any_en;
  assign search_from = (state == ST_IDLE) ? CH_W'(NUM_CH - 1) : cur_ch;

  adc_scan_divider #(.HALF_CLKS(HALF_CLKS)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state == ST_LEAD || state == ST_LOW || state == ST_HIGH),
    .tick (half_tick)
  );

  adc_scan_chansel #(.NUM_CH(NUM_CH)) u_sel (
    .mask   (chan_mask),
    .last   (search_from),
    .next_ch(next_ch),
    .any_en (any_en)
  );

  adc_scan_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   ((state == ST_LOW) && half_tick),
    .din     (spi_miso),
    .word_now(word_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      spi_cs_n    <= 1'b1;
      spi_sclk    <= 1'b1;
      spi_mosi    <= 1'b0;
      bit_cnt     <= '0;
      gap_cnt     <= '0;
      cur_ch      <= '0;
      prev_ch     <= '0;
      dummy_frame <= 1'b0;
      res_valid   <= 1'b0;
      res_chan    <= '0;
      res_code    <= '0;
      res_err     <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      // Result of frame k belongs to the address sent in frame k-1
      if (frame_done) begin
        if (!dummy_frame) begin
          res_valid <= 1'b1;
          res_chan  <= prev_ch;
          res_code  <= word_now[CODE_W-1:0];
          res_err   <= |word_now[WORD_W-1:CODE_W];
        end
        prev_ch     <= cur_ch;
        dummy_frame <= 1'b0;
      end
      case (state)
        ST_IDLE: if (keep_going) begin
          cur_ch      <= next_ch;
          dummy_frame <= 1'b1;
          spi_cs_n    <= 1'b0;
          state       <= ST_LEAD;
        end
        ST_LEAD: if (half_tick) begin
          state    <= ST_LOW;
          spi_sclk <= 1'b0;
          bit_cnt  <= '0;
          spi_mosi <= ctrl_bit('0, cur_ch);
        end
        ST_LOW: if (half_tick) begin
          state    <= ST_HIGH;
          spi_sclk <= 1'b1;
        end
        ST_HIGH: if (half_tick) begin
          if (!frame_end) begin
            bit_cnt  <= bit_cnt + 1'b1;
            spi_sclk <= 1'b0;
            state    <= ST_LOW;
            spi_mosi <= ctrl_bit(bit_cnt + 1'b1, cur_ch);
          end else if (!keep_going) begin
            state    <= ST_IDLE;
            spi_cs_n <= 1'b1;
            spi_mosi <= 1'b0;
          end else if (!burst_mode) begin
            cur_ch   <= next_ch;
            bit_cnt  <= '0;
            spi_sclk <= 1'b0;
            state    <= ST_LOW;
            spi_mosi <= ctrl_bit('0, next_ch);
          end else begin
            state    <= ST_GAP;
            spi_cs_n <= 1'b1;
            spi_mosi <= 1'b0;
            gap_cnt  <= '0;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CLKS - 1)) begin
            if (keep_going) begin
              cur_ch   <= next_ch;
              spi_cs_n <= 1'b0;
              state    <= ST_LEAD;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_mask,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic              res_valid,
  input logic              half_tick,
  input logic              frame_done,
  input logic              dummy_frame
);
  a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  a_r2_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sclk) |-> $past(half_tick));

  a_r3_cs_fall_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> spi_sclk);

  a_r3_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |=> spi_sclk);

  a_r4_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_mosi);

  a_r7_primer_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && dummy_frame) |=> !res_valid);

  a_r9_mask_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mask == '0 && spi_cs_n) |=> spi_cs_n);

  a_r13_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r13_valid_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(spi_sclk));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_mask  (chan_mask),
  .spi_cs_n   (spi_cs_n),
  .spi_sclk   (spi_sclk),
  .spi_mosi   (spi_mosi),
  .res_valid  (res_valid),
  .half_tick  (half_tick),
  .frame_done (frame_done),
  .dummy_frame(dummy_frame)
);

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;
  localparam int HALF = 4;
  localparam int GAP  = 8;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, burst_mode = 1'b0;
  logic [7:0] chan_mask = '0;
  logic spi_miso = 1'b0;
  wire spi_cs_n, spi_sclk, spi_mosi, res_valid, res_err;
  wire [2:0] res_chan;
  wire [11:0] res_code;

  always #4 clk = ~clk;  // 125 MHz

  adc_scan_ctrl #(.HALF_CLKS(HALF), .GAP_CLKS(GAP)) u_adc_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .burst_mode(burst_mode),
    .chan_mask(chan_mask), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .res_valid(res_valid),
    .res_chan(res_chan), .res_code(res_code), .res_err(res_err));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Behavioural converter: code = {converted channel, conversion number}
  logic [2:0]  m_next_ch = 3'd6;
  logic [7:0]  m_ctrl = '0;
  logic [15:0] m_word = '0;
  logic [3:0]  m_lead = '0;
  int m_fall = 0, m_rise = 0, m_conv = 0, bad_ctrl = 0, bad_tail = 0;

  always @(negedge spi_cs_n) begin m_fall = 0; m_rise = 0; end
  always @(posedge spi_cs_n) spi_miso = 1'b0;
  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) begin
    if (m_fall % 16 == 0) begin
      m_word = {m_lead, m_next_ch, 9'(m_conv)};
      m_conv++;
    end
    spi_miso = m_word[15 - (m_fall % 16)];
    m_fall++;
  end
  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    m_ctrl = {m_ctrl[6:0], spi_mosi};
    m_rise++;
    if (m_rise % 16 == 8) begin
      m_next_ch = m_ctrl[5:3];
      if ({m_ctrl[7:6], m_ctrl[2:0]} != 5'd0) bad_ctrl++;
    end else if ((m_rise % 16 > 8 || m_rise % 16 == 0) && spi_mosi) bad_tail++;
  end

  // Port monitor, sampled on the falling system clock edge
  logic [2:0]  got_ch[64];
  logic [11:0] got_code[64];
  logic        got_err[64];
  int got_n = 0, hi_cnt = 0, lo_cnt = 0, cs_hi_cnt = 0;
  int hi_bad = 0, lo_bad = 0, frame_bad = 0, vld_bad = 0, cs_falls = 0, cs_rises = 0;
  int gap_min = 0, gap_max = 0;
  logic p_cs = 1'b1, p_sclk = 1'b1, p_vld = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (res_valid) begin
      if (got_n < 64) begin
        got_ch[got_n] = res_chan; got_code[got_n] = res_code; got_err[got_n] = res_err;
      end
      got_n++;
      if (p_vld || !(spi_sclk && !p_sclk) || m_rise % 16 != 0) vld_bad++;
    end
    if (!spi_sclk) lo_cnt++;
    else if (!p_sclk) begin if (lo_cnt != HALF) lo_bad++; lo_cnt = 0; end
    if (spi_sclk && !spi_cs_n) hi_cnt++;
    if (p_sclk && !spi_sclk) begin if (hi_cnt != HALF) hi_bad++; hi_cnt = 0; end
    if (spi_cs_n) cs_hi_cnt++;
    if (p_cs && !spi_cs_n) begin
      if (cs_falls > 0) begin
        if (gap_min == 0 || cs_hi_cnt < gap_min) gap_min = cs_hi_cnt;
        if (cs_hi_cnt > gap_max) gap_max = cs_hi_cnt;
      end
      cs_falls++;
      cs_hi_cnt = 0;
    end
    if (!p_cs && spi_cs_n) begin
      cs_rises++; hi_cnt = 0;
      if (m_rise == 0 || m_rise % 16 != 0) frame_bad++;
    end
    p_cs = spi_cs_n; p_sclk = spi_sclk; p_vld = res_valid;
  end

  task automatic clear_stats();
    got_n = 0; hi_bad = 0; lo_bad = 0; frame_bad = 0; vld_bad = 0;
    cs_falls = 0; cs_rises = 0; gap_min = 0; gap_max = 0;
    bad_ctrl = 0; bad_tail = 0; m_conv = 0; m_next_ch = 3'd6;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b1, "R1", "cs_n/sclk in reset",
        {spi_cs_n, spi_sclk}, 3);
    chk(spi_mosi === 1'b0 && res_valid === 1'b0, "R1", "mosi/valid in reset",
        {spi_mosi, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && res_valid === 1'b0, "R1", "state after release",
        {spi_cs_n, res_valid}, 2);
  endtask

  // One scan scenario; expected order is built from the mask list
  task automatic test_scan(input logic [7:0] mask, input bit burst, input int n,
                           input logic [3:0] lead, input string name);
    int en[8];
    int k = 0, bad_order = 0, bad_tag = 0, bad_num = 0, bad_err = 0;
    for (int c = 0; c < 8; c++) if (mask[c]) begin en[k] = c; k++; end
    @(posedge clk); #1;
    clear_stats();
    m_lead = lead; chan_mask = mask; burst_mode = burst; run = 1'b1;
    for (int t = 0; t < 40000 && got_n < n; t++) @(negedge clk);
    @(posedge clk); #1;
    run = 1'b0;
    repeat (400) @(negedge clk);
    $display("scenario %s: %0d results", name, got_n);
    chk(got_n >= n, "R8", "result count", got_n, n);
    for (int i = 0; i < got_n && i < 64; i++) begin
      if (int'(got_ch[i]) != en[i % k]) bad_order++;
      if (got_code[i][11:9] != got_ch[i]) bad_tag++;
      if (int'(got_code[i][8:0]) != i + 1) bad_num++;
      if (got_err[i] != (lead != 4'd0)) bad_err++;
    end
    chk(bad_order == 0, "R8", "scan order mismatches", bad_order, 0);
    chk(bad_tag == 0, "R6", "tag vs converted channel mismatches", bad_tag, 0);
    chk(bad_num == 0, "R5", "code bits mismatches", bad_num, 0);
    chk(got_n > 0 && int'(got_code[0][8:0]) == 1, "R7", "first result conversion no.",
        int'(got_code[0][8:0]), 1);
    chk(bad_err == 0, "R12", "error flag mismatches", bad_err, 0);
    chk(bad_ctrl == 0 && bad_tail == 0, "R4", "bad control bits", bad_ctrl + bad_tail, 0);
    chk(hi_bad == 0 && lo_bad == 0, "R2", "bad clock phases", hi_bad + lo_bad, 0);
    chk(frame_bad == 0, "R2", "partial frames", frame_bad, 0);
    chk(vld_bad == 0, "R13", "bad valid pulses", vld_bad, 0);
    chk(m_conv == got_n + 1, "R7", "frames vs results", m_conv, got_n + 1);
    chk(spi_cs_n === 1'b1, "R9", "idle after run drop", spi_cs_n, 1);
    if (burst) begin
      chk(cs_falls == got_n + 1, "R11", "chip select falls", cs_falls, got_n + 1);
      chk(gap_min == GAP && gap_max == GAP, "R11", "gap length", gap_max, GAP);
    end else begin
      chk(cs_falls == 1 && cs_rises == 1, "R10", "chip select toggles",
          cs_falls + cs_rises, 2);
    end
  endtask

  task automatic test_mask_zero();
    @(posedge clk); #1;
    clear_stats();
    chan_mask = 8'h00; burst_mode = 1'b0; run = 1'b1;
    repeat (500) @(negedge clk);
    chk(cs_falls == 0 && got_n == 0, "R9", "activity with zero mask", cs_falls + got_n, 0);
    @(posedge clk); #1;
    run = 1'b0; chan_mask = 8'hFF;
    repeat (500) @(negedge clk);
    chk(cs_falls == 0 && got_n == 0, "R9", "activity with run low", cs_falls + got_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_scan(8'hFF, 1'b0, 10, 4'h0, "full mask continuous");
    test_scan(8'b1010_0100, 1'b0, 9, 4'h0, "sparse mask wrap");
    test_scan(8'h81, 1'b1, 6, 4'h0, "burst two channels");
    test_scan(8'h10, 1'b0, 4, 4'b0100, "single channel with leading one");
    test_mask_zero();
    finish_run();
  end
endmodule